// File: doc/BRIEF.md
# Complex Accumulator with Output Scaling

This block sums a stream of complex samples. Each sample arrives as a 16-bit two's-complement real word and a 16-bit two's-complement imaginary word. Each word has its own input register with an active-low load enable. The two parts are summed in separate 20-bit adder/subtractor lanes. Each lane has its own operation code, so the lanes can add, subtract, pass or negate independently. One shared feedback select decides, for both lanes, whether a lane combines its operand with its running total or starts from zero. One shared clear starts both totals afresh.

A scaling code chooses which 16-bit window of each 20-bit total reaches the registered outputs. A single overflow flag reports two kinds of fault: a total that does not fit the chosen window, and a lane sum that wrapped past 20 bits.

For use behind a complex multiplier whose real product is ready one cycle late, a delay select feeds the real lane from the previous contents of the real input register. Each output has an active-low enable. When that enable is high the port reads zero, while the registered value is kept.

Top module: `cplx_accum`

## Requirements
- R1: While `rst` is high at a rising edge, all registers clear. After that edge `re_out`, `im_out` and `ovf` read zero.
- R2: An input register loads its data word at a rising edge only when its enable (`re_en_n` or `im_en_n`) is low. When the enable is high the register keeps its value.
- R3: The operation codes are: 00 gives the operand, 01 gives term plus operand, 10 gives term minus operand, and 11 gives minus operand. The operand is the register word sign-extended to 20 bits.
- R4: When `fb_sel` is high and `acc_clr` is low, the term is the lane's running total. Otherwise the term is zero.
- R5: `acc_clr` high forces the term to zero in both lanes, whatever the value of `fb_sel`.
- R6: All data and control inputs are registered before use. Values sampled at rising edge k appear on the outputs after rising edge k+2.
- R7: Scaling codes 0, 1, 2, 3 and 4 select total bits [15:0], [16:1], [17:2], [18:3] and [19:4]. Codes 5, 6 and 7 act as code 4.
- R8: `ovf` is high when, in either lane, the total bits above the selected window are not all copies of the window's top bit.
- R9: A lane result outside the signed 20-bit range is stored wrapped to 20 bits, and it raises `ovf` in the same cycle its window appears.
- R10: With `re_dly_sel` high, the real lane's operand is the value the real input register held one cycle earlier.
- R11: `re_oe_n` or `im_oe_n` high drives that output to zero at once. The registered value is unaffected and shows again when the enable returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| re_in | input | 16 | Real data word |
| im_in | input | 16 | Imaginary data word |
| re_en_n | input | 1 | Real input register load enable, active low |
| im_en_n | input | 1 | Imaginary input register load enable, active low |
| re_mode | input | 2 | Real lane operation code |
| im_mode | input | 2 | Imaginary lane operation code |
| acc_clr | input | 1 | Clear both running totals |
| fb_sel | input | 1 | Select running total as term for both lanes |
| scale_sel | input | 3 | Output window code |
| re_dly_sel | input | 1 | Feed real lane from delayed real word |
| re_oe_n | input | 1 | Real output enable, active low |
| im_oe_n | input | 1 | Imaginary output enable, active low |
| re_out | output | 16 | Real window of the total |
| im_out | output | 16 | Imaginary window of the total |
| ovf | output | 1 | Window or lane overflow |

## Verification
A behavioural model predicts every output on every cycle. It is run through several input patterns, in this order:

- Single operations in each code, with feedback off and then on. These separate the four operation codes from the feedback path.
- Long runs of a constant word with feedback on. These show that the total really accumulates, and they push it past the 20-bit range so that window overflow and lane wrap are told apart.
- A clear pulse raised while feedback is on.
- A sweep over all eight scaling codes.
- Changing data with the enables high.
- Changing data with the delay select toggled.

Random control mixes then check that data and controls stay aligned through the two-stage register path.

// File: rtl/cacc_pkg.sv
package cacc_pkg;
  localparam int SCALE_W = 3;

  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_NEG  = 2'b11
  } op_mode_e;
endpackage

// File: rtl/cacc_in_reg.sv
module cacc_in_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!en_n) q <= d;
  end

  // R2: a high enable keeps the stored word
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    en_n |=> (q == $past(q)));
endmodule

// File: rtl/cacc_addsub.sv
module cacc_addsub
  import cacc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] opnd,
  input  op_mode_e      mode,
  input  logic          clr,
  input  logic          fb,
  output logic [AW-1:0] acc,
  output logic          add_ovf
);
  localparam int EXT = AW + 1 - DW;

  logic signed [AW:0] a_ext, t_ext, sum;

  always_comb begin
    a_ext = {{EXT{opnd[DW-1]}}, opnd};
    t_ext = (clr || !fb) ? '0 : {acc[AW-1], acc};
    case (mode)
      OP_PASS: sum = a_ext;
      OP_ADD:  sum = t_ext + a_ext;
      OP_SUB:  sum = t_ext - a_ext;
      default: sum = -a_ext;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      add_ovf <= 1'b0;
    end else begin
      acc     <= sum[AW-1:0];
      add_ovf <= (sum[AW] != sum[AW-1]);
    end
  end

  // R4: adding zero to the fed-back total leaves it unchanged
  assert_feedback_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (fb && !clr && mode == OP_ADD && opnd == '0) |=> (acc == $past(acc)));

  // R5: clear drops the old total, so add yields just the operand
  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr && mode == OP_ADD) |=> (acc == {{(AW-DW){$past(opnd[DW-1])}}, $past(opnd)}));

  // R9: negating a narrow operand can never leave the wide range
  assert_neg_safe_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == OP_NEG) |=> !add_ovf);
endmodule

// File: rtl/cacc_scaler.sv
module cacc_scaler #(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] acc,
  input  logic [SW-1:0] scale,
  input  logic          add_ovf,
  output logic [DW-1:0] slice_q,
  output logic          ovf_q
);
  localparam int MAXSH = AW - DW;

  int                 sh;
  logic signed [AW-1:0] acc_s, shifted, top;
  logic               win_ovf;

  always_comb begin
    sh      = (int'(scale) > MAXSH) ? MAXSH : int'(scale);
    acc_s   = acc;
    shifted = acc_s >>> sh;
    top     = acc_s >>> (sh + DW - 1);
    win_ovf = !((top == '0) || (top == '1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slice_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      slice_q <= shifted[DW-1:0];
      ovf_q   <= win_ovf | add_ovf;
    end
  end

  // R7/R8: the top window holds every total, so only a lane wrap can flag
  assert_top_window_R7: assert property (@(posedge clk) disable iff (rst)
    ((int'(scale) >= MAXSH) && !add_ovf) |=> !ovf_q);
endmodule

// File: rtl/cplx_accum.sv
module cplx_accum
  import cacc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int SW = SCALE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] re_in,
  input  logic [DW-1:0] im_in,
  input  logic          re_en_n,
  input  logic          im_en_n,
  input  logic [1:0]    re_mode,
  input  logic [1:0]    im_mode,
  input  logic          acc_clr,
  input  logic          fb_sel,
  input  logic [SW-1:0] scale_sel,
  input  logic          re_dly_sel,
  input  logic          re_oe_n,
  input  logic          im_oe_n,
  output logic [DW-1:0] re_out,
  output logic [DW-1:0] im_out,
  output logic          ovf
);
  localparam int LANES = 2;

  logic [DW-1:0] din     [LANES];
  logic          en_n    [LANES];
  logic [DW-1:0] din_q   [LANES];
  logic [DW-1:0] opnd    [LANES];
  logic [AW-1:0] acc     [LANES];
  logic          add_ovf [LANES];
  logic [DW-1:0] slice   [LANES];
  logic          lane_ovf[LANES];
  op_mode_e      mode_q  [LANES];

  logic          clr_q, fb_q, dly_q;
  logic [SW-1:0] scale_q, scale_q2;
  logic [DW-1:0] re_prev;

  assign din[0]  = re_in;
  assign din[1]  = im_in;
  assign en_n[0] = re_en_n;
  assign en_n[1] = im_en_n;

  // control capture, then scale follows the data one more stage
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q[0] <= OP_PASS;
      mode_q[1] <= OP_PASS;
      clr_q     <= 1'b0;
      fb_q      <= 1'b0;
      dly_q     <= 1'b0;
      scale_q   <= '0;
      scale_q2  <= '0;
      re_prev   <= '0;
    end else begin
      mode_q[0] <= op_mode_e'(re_mode);
      mode_q[1] <= op_mode_e'(im_mode);
      clr_q     <= acc_clr;
      fb_q      <= fb_sel;
      dly_q     <= re_dly_sel;
      scale_q   <= scale_sel;
      scale_q2  <= scale_q;
      re_prev   <= din_q[0];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cacc_in_reg #(.W(DW)) i_in (
      .clk(clk), .rst(rst), .en_n(en_n[g]), .d(din[g]), .q(din_q[g])
    );

    if (g == 0) begin : g_dly
      assign opnd[g] = dly_q ? re_prev : din_q[g];
    end else begin : g_nodly
      assign opnd[g] = din_q[g];
    end

    cacc_addsub #(.DW(DW), .AW(AW)) i_as (
      .clk(clk), .rst(rst), .opnd(opnd[g]), .mode(mode_q[g]),
      .clr(clr_q), .fb(fb_q), .acc(acc[g]), .add_ovf(add_ovf[g])
    );

    cacc_scaler #(.DW(DW), .AW(AW), .SW(SW)) i_sc (
      .clk(clk), .rst(rst), .acc(acc[g]), .scale(scale_q2),
      .add_ovf(add_ovf[g]), .slice_q(slice[g]), .ovf_q(lane_ovf[g])
    );
  end

  assign re_out = re_oe_n ? '0 : slice[0];
  assign im_out = im_oe_n ? '0 : slice[1];
  assign ovf    = lane_ovf[0] | lane_ovf[1];

  // R1: a reset edge leaves quiet outputs
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (re_out == '0 && im_out == '0 && !ovf));
endmodule

// File: tb/test_cplx_accum.sv
`timescale 1ns/1ps
module test_cplx_accum;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic [15:0] re_in = '0, im_in = '0;
  logic        re_en_n = 1'b0, im_en_n = 1'b0;
  logic [1:0]  re_mode = '0, im_mode = '0;
  logic        acc_clr = 1'b0, fb_sel = 1'b0, re_dly_sel = 1'b0;
  logic [2:0]  scale_sel = '0;
  logic        re_oe_n = 1'b0, im_oe_n = 1'b0;
  logic [15:0] re_out, im_out;
  logic        ovf;

  cplx_accum i_cplx_accum (
    .clk(clk), .rst(rst), .re_in(re_in), .im_in(im_in),
    .re_en_n(re_en_n), .im_en_n(im_en_n), .re_mode(re_mode), .im_mode(im_mode),
    .acc_clr(acc_clr), .fb_sel(fb_sel), .scale_sel(scale_sel),
    .re_dly_sel(re_dly_sel), .re_oe_n(re_oe_n), .im_oe_n(im_oe_n),
    .re_out(re_out), .im_out(im_out), .ovf(ovf)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model state
  int m_q[2], m_prev, m_mode[2], m_clr, m_fb, m_dly, m_sc, m_sc2;
  int m_acc[2], m_aov[2], m_out[2], m_ovf;

  function automatic int wrap20(longint v);
    longint r = v & 64'hFFFFF;
    if (r >= 64'h80000) r -= 64'h100000;
    return int'(r);
  endfunction

  function automatic int lane_calc(int mode, int t, int a);
    case (mode)
      0: return a;
      1: return t + a;
      2: return t - a;
      default: return -a;
    endcase
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_q = '{0, 0}; m_prev = 0; m_mode = '{0, 0};
      m_clr = 0; m_fb = 0; m_dly = 0; m_sc = 0; m_sc2 = 0;
      m_acc = '{0, 0}; m_aov = '{0, 0}; m_out = '{0, 0}; m_ovf = 0;
    end else begin
      int s, lim, win, a, t, r;
      // output stage
      s = (m_sc2 > 4) ? 4 : m_sc2;
      lim = 1 << (15 + s);
      win = 0;
      for (int l = 0; l < 2; l++) begin
        m_out[l] = (m_acc[l] >>> s) & 16'hFFFF;
        if (m_acc[l] >= lim || m_acc[l] < -lim) win = 1;
      end
      m_ovf = win | m_aov[0] | m_aov[1];
      // lane stage
      for (int l = 0; l < 2; l++) begin
        a = (l == 0 && m_dly != 0) ? m_prev : m_q[l];
        t = (m_clr != 0 || m_fb == 0) ? 0 : m_acc[l];
        r = lane_calc(m_mode[l], t, a);
        m_aov[l] = (r > 524287 || r < -524288) ? 1 : 0;
        m_acc[l] = wrap20(r);
      end
      m_sc2 = m_sc;
      // capture stage
      m_prev = m_q[0];
      if (!re_en_n) m_q[0] = int'($signed(re_in));
      if (!im_en_n) m_q[1] = int'($signed(im_in));
      m_mode[0] = int'(re_mode); m_mode[1] = int'(im_mode);
      m_clr = acc_clr; m_fb = fb_sel; m_dly = re_dly_sel; m_sc = int'(scale_sel);
    end
  endtask

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check("re_out", int'(re_out), re_oe_n ? 0 : m_out[0]);
      check("im_out", int'(im_out), im_oe_n ? 0 : m_out[1]);
      check("ovf",    int'(ovf),    m_ovf);
    end
  endtask

  task automatic drive(int re, int im, int rm, int im_m, int fb, int clr);
    re_in = 16'(re); im_in = 16'(im);
    re_mode = 2'(rm); im_mode = 2'(im_m);
    fb_sel = 1'(fb); acc_clr = 1'(clr);
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    re_in = 16'h1234; im_in = 16'h4321;
    cyc(3);
    @(negedge clk); rst = 1'b0;
    drive(0, 0, 0, 0, 0, 0);
    cyc(3);

    // R3: each operation code, feedback off then on
    tag = "R3";
    for (int m = 0; m < 4; m++) begin
      drive(1000 + m, -2000 - m, m, 3 - m, 0, 0); cyc(1);
      drive(-300, 700, m, m, 1, 0); cyc(1);
      drive(555, -555, m, (m + 1) % 4, 1, 0); cyc(1);
    end
    cyc(3);

    // R4: steady accumulation through feedback
    tag = "R4";
    drive(1000, -750, 1, 1, 1, 1); cyc(1);
    drive(1000, -750, 1, 1, 1, 0); cyc(12);
    drive(250, 250, 2, 2, 1, 0); cyc(6);

    // R5: clear while feedback is selected
    tag = "R5";
    drive(77, -88, 1, 1, 1, 1); cyc(1);
    drive(77, -88, 1, 1, 1, 0); cyc(4);
    drive(0, 0, 1, 1, 1, 1); cyc(4);

    // R7: every scaling code on a large total
    tag = "R7";
    drive(20000, -20000, 1, 1, 1, 0); cyc(5);
    drive(0, 0, 1, 1, 1, 0);
    for (int s = 0; s < 8; s++) begin scale_sel = 3'(s); cyc(2); end
    scale_sel = 3'd0; cyc(3);

    // R8: window overflow grows with the total at a narrow window
    tag = "R8";
    drive(9000, 100, 1, 1, 1, 1); cyc(1);
    drive(9000, 100, 1, 1, 1, 0); cyc(8);
    scale_sel = 3'd2; cyc(4);

    // R9: lane wrap past the 20-bit range
    tag = "R9";
    scale_sel = 3'd4;
    drive(32767, -32768, 1, 1, 1, 1); cyc(1);
    drive(32767, -32768, 1, 1, 1, 0); cyc(24);
    drive(0, 0, 0, 0, 0, 0); scale_sel = 3'd0; cyc(4);

    // R2: enables high hold the captured words
    tag = "R2";
    drive(111, 222, 0, 0, 0, 0); cyc(2);
    re_en_n = 1'b1;
    for (int i = 0; i < 4; i++) begin drive(3000 + i, 400 + i, 0, 0, 0, 0); cyc(1); end
    im_en_n = 1'b1; re_en_n = 1'b0;
    for (int i = 0; i < 4; i++) begin drive(-50 - i, 9999 + i, 0, 0, 0, 0); cyc(1); end
    im_en_n = 1'b0; cyc(4);

    // R10: delayed real operand
    tag = "R10";
    for (int i = 0; i < 8; i++) begin
      re_dly_sel = 1'(i % 3 == 1);
      drive(100 * i - 350, 17 * i, 0, 0, 0, 0); cyc(1);
    end
    re_dly_sel = 1'b1;
    for (int i = 0; i < 5; i++) begin drive(i * 1111, -i, 1, 1, 1, 0); cyc(1); end
    re_dly_sel = 1'b0; cyc(4);

    // R11: output enables zero the ports and keep the registered value
    tag = "R11";
    drive(4321, -1234, 0, 0, 0, 0); cyc(4);
    re_oe_n = 1'b1; cyc(2);
    im_oe_n = 1'b1; re_oe_n = 1'b0; cyc(2);
    im_oe_n = 1'b0; cyc(2);

    // R6: random control mixes across the register path
    tag = "R6";
    for (int i = 0; i < 400; i++) begin
      drive(int'($urandom), int'($urandom), int'($urandom % 4), int'($urandom % 4),
            int'($urandom % 4 != 0), int'($urandom % 16 == 0));
      re_en_n = 1'($urandom % 5 == 0); im_en_n = 1'($urandom % 5 == 0);
      re_dly_sel = 1'($urandom % 3 == 0);
      scale_sel = 3'($urandom);
      re_oe_n = 1'($urandom % 8 == 0); im_oe_n = 1'($urandom % 8 == 0);
      cyc(1);
    end

    // R1: reset mid-stream
    tag = "R1";
    re_oe_n = 1'b0; im_oe_n = 1'b0;
    rst = 1'b1; cyc(2);
    rst = 1'b0; drive(0, 0, 0, 0, 0, 0); cyc(3);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL %s watchdog actual=timeout expected=finished", tag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule